// File: doc/BRIEF.md
# Parallel Bus Exerciser Pattern Generator

This block takes over an 8-bit address bus, an 8-bit data bus and two strobe lines and drives a fixed, endlessly repeating test pattern onto them. With the pattern running, a stuck, open or shorted line can be spotted on a scope or logic analyser. Such a line stays constant, moves together with a neighbour, or breaks the halving of toggle rates from one bit to the next. The address and data buses are never driven in the same phase. A data-valid strobe frames each step: the address moves only while it is low, and the data moves only while it is high.

One sweep has a preamble step followed by 256 count steps. Each step lasts four clocks: present the address with the strobe low, raise the strobe, present the data, lower the strobe. During the preamble the address is zero and only the upper half of the data bus pulses high. This marks the start of the sweep and is not part of the binary count. The poll line is high for the first half of the sweep and low for the second. A one-cycle marker flags the first cycle of every sweep.

While the enable input is high the pattern repeats without end. Dropping the enable, or applying reset, returns every output to zero. The next enable then begins a fresh sweep.

Top module: `bus_exerciser`

## Requirements
- R1: While reset is high, or on any cycle that follows a clock edge where the enable was low, every output is zero.
- R2: `sweep_start` is high for exactly one cycle at the start of each sweep. While enabled, sweeps repeat every 1028 cycles: (1 preamble + 256 count steps) × 4 clocks.
- R3: Within each step, `bus_valid` reads 0,1,1,0 over the four cycles, so each high pulse lasts two cycles.
- R4: `bus_addr` changes only in a cycle where `bus_valid` is low and was also low in the previous cycle.
- R5: `bus_data` changes only in a cycle where `bus_valid` is high and was also high in the previous cycle.
- R6: In count step k (k = 0..255, after the preamble), `bus_addr` equals k. The count wraps from 255 back to a new preamble.
- R7: In count step k, `bus_data` takes the value k in the step's third cycle and holds it until the third cycle of the next step.
- R8: In the preamble, `bus_addr` is 0. `bus_data` becomes 0xF0 (upper four bits set, lower four clear) in its third cycle. The lower four data bits never take part in this pulse.
- R9: While active, `bus_poll` is high when `bus_addr` bit 7 is 0, and low when it is 1.
- R10: After a disable or reset, the first active cycle after the enable is sampled high is a sweep start. At that point `bus_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exer_en | input | 1 | Exercise mode enable |
| bus_addr | output | 8 | Address bus pattern |
| bus_data | output | 8 | Data bus pattern |
| bus_valid | output | 1 | Data-valid strobe |
| bus_poll | output | 1 | Poll strobe |
| sweep_start | output | 1 | One-cycle marker at the first cycle of each sweep |

## Verification
A wrong phase counter shows at the ports within four cycles. The strobe pulse takes the wrong shape, or an address or data change lands on the wrong strobe level.

A wrong step counter or a broken wrap shows up differently. The address skips or repeats a value, the marker arrives at the wrong spacing, or the preamble pulse is missing, and this is visible within one sweep of 1028 cycles.

A data register that is not loaded or not cleared shows as a data value that lags the address, or as a nonzero data bus on the first cycle after re-enable.

// File: rtl/exb_pkg.sv
package exb_pkg;
  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_RISE = 2'd1,
    PH_DATA = 2'd2,
    PH_FALL = 2'd3
  } phase_e;
endpackage

// File: rtl/exb_seq.sv
module exb_seq
  import exb_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic             act_o,
  output logic             pre_o,
  output phase_e           phase_o,
  output logic [BUS_W-1:0] step_o
);
  localparam logic [BUS_W-1:0] STEP_MAX = {BUS_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      act_o   <= 1'b0;
      pre_o   <= 1'b1;
      phase_o <= PH_ADDR;
      step_o  <= '0;
    end else if (!act_o) begin
      act_o <= 1'b1;
    end else begin
      phase_o <= phase_e'(phase_o + 2'd1);
      if (phase_o == PH_FALL) begin
        if (pre_o) begin
          pre_o <= 1'b0;
        end else if (step_o == STEP_MAX) begin
          step_o <= '0;
          pre_o  <= 1'b1;
        end else begin
          step_o <= step_o + 1'b1;
        end
      end
    end
  end

  // R6
  step_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (act_o && $past(act_o) && (step_o != $past(step_o)))
      |-> ((step_o == $past(step_o) + 1'b1) || (step_o == '0 && $past(step_o) == STEP_MAX)));
endmodule

// File: rtl/exb_drive.sv
module exb_drive
  import exb_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             act_i,
  input  logic             pre_i,
  input  phase_e           phase_i,
  input  logic [BUS_W-1:0] step_i,
  output logic [BUS_W-1:0] addr_o,
  output logic [BUS_W-1:0] data_o,
  output logic             dv_o,
  output logic             poll_o,
  output logic             frame_o
);
  localparam int HALF_W = BUS_W / 2;
  localparam logic [BUS_W-1:0] MARK = {{(BUS_W-HALF_W){1'b1}}, {HALF_W{1'b0}}};

  logic [BUS_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst || !en)
      data_q <= '0;
    else if (act_i && phase_i == PH_RISE)
      data_q <= pre_i ? MARK : step_i;
  end

  always_comb begin
    addr_o  = act_i ? step_i : '0;
    data_o  = act_i ? data_q : '0;
    dv_o    = act_i && (phase_i == PH_RISE || phase_i == PH_DATA);
    poll_o  = act_i && !step_i[BUS_W-1];
    frame_o = act_i && pre_i && (phase_i == PH_ADDR);
  end

  // R4
  addr_move_chk: assert property (@(posedge clk) disable iff (rst)
    (act_i && $past(act_i) && !$stable(addr_o)) |-> (!dv_o && !$past(dv_o)));
  // R5
  data_move_chk: assert property (@(posedge clk) disable iff (rst)
    (act_i && $past(act_i) && !$stable(data_o)) |-> (dv_o && $past(dv_o)));
  // R3
  dv_min_width_chk: assert property (@(posedge clk) disable iff (rst)
    (act_i && $rose(dv_o)) |=> (dv_o || !act_i));
  // R3
  dv_max_width_chk: assert property (@(posedge clk) disable iff (rst)
    (dv_o && $past(dv_o)) |=> !dv_o);
  // R2
  frame_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_o |=> !frame_o);
endmodule

// File: rtl/bus_exerciser.sv
module bus_exerciser
  import exb_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             exer_en,
  output logic [BUS_W-1:0] bus_addr,
  output logic [BUS_W-1:0] bus_data,
  output logic             bus_valid,
  output logic             bus_poll,
  output logic             sweep_start
);
  logic             act;
  logic             pre;
  phase_e           phase;
  logic [BUS_W-1:0] step;

  exb_seq #(.BUS_W(BUS_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .en      (exer_en),
    .act_o   (act),
    .pre_o   (pre),
    .phase_o (phase),
    .step_o  (step)
  );

  exb_drive #(.BUS_W(BUS_W)) u_drive (
    .clk     (clk),
    .rst     (rst),
    .en      (exer_en),
    .act_i   (act),
    .pre_i   (pre),
    .phase_i (phase),
    .step_i  (step),
    .addr_o  (bus_addr),
    .data_o  (bus_data),
    .dv_o    (bus_valid),
    .poll_o  (bus_poll),
    .frame_o (sweep_start)
  );
endmodule

// File: tb/bus_exerciser_tb.sv
module bus_exerciser_tb;
  localparam int SWEEP = 1028;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       exer_en = 1'b0;
  logic [7:0] bus_addr, bus_data;
  logic       bus_valid, bus_poll, sweep_start;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model state, derived from the requirements
  bit       m_act = 1'b0;
  int       m_c = 0;
  bit [7:0] m_data = 8'h00;
  bit       was_act = 1'b0;
  logic [7:0] prev_addr = 8'h00, prev_data = 8'h00;
  logic       prev_dv = 1'b0;

  always #10 clk = ~clk;

  bus_exerciser u_dut (
    .clk(clk), .rst(rst), .exer_en(exer_en),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_valid(bus_valid),
    .bus_poll(bus_poll), .sweep_start(sweep_start)
  );

  function automatic bit [7:0] exp_addr(int c);
    int s = c / 4;
    return (s == 0) ? 8'h00 : 8'(s - 1);
  endfunction

  function automatic bit exp_dv(int c);
    return (c % 4 == 1) || (c % 4 == 2);
  endfunction

  task automatic chk(input string tag, input logic [15:0] actual, input logic [15:0] expected);
    n_chk++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h (sweep cycle %0d)", tag, actual, expected, m_c);
    end
  endtask

  task automatic check_outputs();
    if (!m_act) begin
      chk("R1 addr idle", {8'h0, bus_addr}, 16'h0);
      chk("R1 data idle", {8'h0, bus_data}, 16'h0);
      chk("R1 strobes idle", {13'h0, bus_valid, bus_poll, sweep_start}, 16'h0);
    end else begin
      chk("R2 sweep_start", {15'h0, sweep_start}, {15'h0, (m_c == 0)});
      chk("R3 bus_valid", {15'h0, bus_valid}, {15'h0, exp_dv(m_c)});
      if (m_c / 4 == 0) chk("R8 preamble addr", {8'h0, bus_addr}, 16'h0);
      else chk("R6 addr count", {8'h0, bus_addr}, {8'h0, exp_addr(m_c)});
      if (m_c / 4 == 0 && m_c % 4 >= 2) chk("R8 preamble data", {8'h0, bus_data}, 16'h00F0);
      else chk("R7 data", {8'h0, bus_data}, {8'h0, m_data});
      chk("R9 poll", {15'h0, bus_poll}, {15'h0, ~exp_addr(m_c)[7]});
      if (!was_act) begin
        chk("R10 restart marker", {15'h0, sweep_start}, 16'h1);
        chk("R10 restart data", {8'h0, bus_data}, 16'h0);
      end else begin
        if (bus_addr !== prev_addr)
          chk("R4 addr moves with valid low", {14'h0, prev_dv, bus_valid}, 16'h0);
        if (bus_data !== prev_data)
          chk("R5 data moves with valid high", {14'h0, prev_dv, bus_valid}, 16'h3);
      end
    end
    was_act   = m_act;
    prev_addr = bus_addr;
    prev_data = bus_data;
    prev_dv   = bus_valid;
  endtask

  task automatic model_step();
    if (rst || !exer_en) begin
      m_act = 1'b0; m_c = 0; m_data = 8'h00;
    end else if (!m_act) begin
      m_act = 1'b1; m_c = 0;
    end else begin
      m_c = (m_c == SWEEP - 1) ? 0 : m_c + 1;
      if (m_c % 4 == 2) m_data = (m_c / 4 == 0) ? 8'hF0 : 8'(m_c / 4 - 1);
    end
  endtask

  task automatic cycle(input bit r, input bit e);
    @(negedge clk);
    check_outputs();
    rst = r;
    exer_en = e;
    model_step();
  endtask

  initial begin
    int off_left;
    void'($urandom(32'd2024));
    // reset state
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0);
    // two full sweeps and a wrap
    for (int i = 0; i < 2 * SWEEP + 300; i++) cycle(1'b0, 1'b1);
    // disable mid sweep, then restart
    for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0);
    for (int i = 0; i < 700; i++) cycle(1'b0, 1'b1);
    // reset while enabled
    cycle(1'b1, 1'b1);
    for (int i = 0; i < 40; i++) cycle(1'b0, 1'b1);
    // random enable drops and resets
    off_left = 0;
    for (int i = 0; i < 5000; i++) begin
      bit r = ($urandom_range(0, 1999) == 0);
      if (off_left == 0 && $urandom_range(0, 399) == 0) off_left = $urandom_range(1, 6);
      if (off_left > 0) begin
        off_left--;
        cycle(r, 1'b0);
      end else begin
        cycle(r, 1'b1);
      end
    end
    cycle(1'b0, 1'b0);
    cycle(1'b0, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule